// File: doc/BRIEF.md
# Serial Display Command and Pixel Transmitter

This block is a transmit-only serial master for small display panel controllers. Upstream logic hands it one byte at a time on a valid/ready pair, each byte tagged as either a command or data (pixel or parameter). The block frames the bytes with an active-low select, generates the serial clock from the system clock, and shifts the bits out most significant first. The clock idles low, the output bit changes on the falling edge, and the panel samples it on the rising edge.

Two wiring modes are selectable. In four-wire mode a separate command/data output carries the tag for each byte. In three-wire mode that output is unused and held low. Instead, each byte is preceded on the serial line by a tag bit, so every frame is nine bits long. The serial clock rate is the system clock divided by 2×(DIV+1), where DIV is an input. DIV is captured when a burst opens. Bytes that arrive back to back share one select window. The select returns high half a serial clock period after the final bit.

Top module: `panel_serial_tx`

## Requirements
- R1: While reset is asserted and right after it is released: `cs_n`=1, `sclk`=0, `sdo`=0, `dc`=0 and `in_ready`=1.
- R2: `sclk` is low whenever `cs_n` is high. While `cs_n` is low, every `sclk` level lasts exactly DIV+1 clock cycles, where DIV is the `cfg_div` value captured when the burst opens. This includes the span from the fall of `cs_n` to the first rising edge.
- R3: In four-wire mode (`cfg_three_wire`=0), each byte is sent as 8 rising edges, most significant bit first. `dc` is 1 for data and 0 for a command, and it is constant across all rising edges of its frame.
- R4: In three-wire mode (`cfg_three_wire`=1), each byte is sent as 9 rising edges. The first bit is the tag (0 command, 1 data), followed by the byte most significant bit first. `dc` stays 0.
- R5: `sdo` does not change while `sclk` is high.
- R6: A byte that is offered while the previous frame is still in progress is sent in the same `cs_n` window, with no rise of `cs_n` between the two. A byte offered after the window has closed opens a new window.
- R7: When no further byte is offered, `cs_n` rises exactly DIV+1 cycles after the final falling edge of `sclk`, and never partway through a frame. `in_ready` is high only in idle or in the last cycle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_three_wire | input | 1 | 1 selects 9-bit tagged frames, 0 selects the separate tag output |
| cfg_div | input | DIV_W | Half-period length minus one, in clock cycles |
| in_valid | input | 1 | A byte is offered |
| in_is_data | input | 1 | Tag of the offered byte: 1 data, 0 command |
| in_byte | input | BYTE_W | Byte to send |
| in_ready | output | 1 | Offered byte is taken on this clock edge if valid |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low panel select |
| dc | output | 1 | Command/data tag in four-wire mode, held low in three-wire mode |

## Verification
A wrong count in the divider shows up at the very next `sclk` edge as a half period whose length is not DIV+1 cycles. A wrong bit counter or a wrong shift register load shows up within one frame: there is a wrong number of rising edges before `cs_n` rises, or the decoded word carries a misplaced or missing tag bit. A control state that stays active too long or closes too early is visible at the end of each burst. Either `cs_n` rises at the wrong distance from the last falling edge, or a burst is split into several select windows.

// File: rtl/panel_tx_pkg.sv
package panel_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_TAIL = 2'd3
  } link_state_t;
endpackage

// File: rtl/half_tick_gen.sv
module half_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the counter never passes the captured half-period length
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              three_wire,
  input  logic              is_data,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              sdo,
  output logic              last
);
  localparam int FRAME_W = BYTE_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   rem_q, rem_d;
  logic               en;

  assign en   = load || shift;
  assign sdo  = sh_q[FRAME_W-1];
  assign last = (rem_q == CNT_W'(1));

  always_comb begin
    sh_d  = sh_q;
    rem_d = rem_q;
    if (load) begin
      if (three_wire) begin
        sh_d  = {is_data, byte_in};
        rem_d = CNT_W'(FRAME_W);
      end else begin
        sh_d  = {byte_in, 1'b0};
        rem_d = CNT_W'(BYTE_W);
      end
    end else if (shift) begin
      sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      rem_q <= rem_d;
    end
  end

  // R3: never shift past the end of a frame
  assert_no_overshift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |-> (rem_q > CNT_W'(1)));
endmodule

// File: rtl/link_ctrl.sv
module link_ctrl
  import panel_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_is_data,
  input  logic three_wire,
  input  logic tick,
  input  logic last,
  output logic load,
  output logic shift,
  output logic in_ready,
  output logic busy,
  output logic sclk,
  output logic cs_n,
  output logic dc
);
  link_state_t state_q, state_d;
  logic sclk_q, cs_n_q, dc_q, dc_d;

  assign busy     = (state_q != ST_IDLE);
  assign in_ready = (state_q == ST_IDLE) || ((state_q == ST_HI) && tick && last);
  assign load     = in_valid && in_ready;

  always_comb begin
    state_d = state_q;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (in_valid) state_d = ST_LO;
      ST_LO:   if (tick) state_d = ST_HI;
      ST_HI: begin
        if (tick) begin
          if (!last) begin
            shift   = 1'b1;
            state_d = ST_LO;
          end else if (in_valid) begin
            state_d = ST_LO;
          end else begin
            state_d = ST_TAIL;
          end
        end
      end
      ST_TAIL: if (tick) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    dc_d = dc_q;
    if (load) dc_d = three_wire ? 1'b0 : in_is_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      dc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= (state_d == ST_HI);
      cs_n_q  <= (state_d == ST_IDLE);
      dc_q    <= dc_d;
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_n_q;
  assign dc   = dc_q;

  // R3: the tag output moves only when a new byte has been taken
  assert_dc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dc_q) |-> $past(load));
  // R7: ready is offered only in idle or at the last edge of a frame
  assert_ready_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (state_q == ST_IDLE || state_q == ST_HI));
  // R7: select never rises while the clock is high
  assert_cs_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> !$past(sclk_q));
endmodule

// File: rtl/panel_serial_tx.sv
module panel_serial_tx
  import panel_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_three_wire,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              in_valid,
  input  logic              in_is_data,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              sclk,
  output logic              sdo,
  output logic              cs_n,
  output logic              dc
);
  logic             tick, last, load, shift, busy, open_burst;
  logic [DIV_W-1:0] div_q, div_d;

  assign open_burst = load && !busy;

  always_comb begin
    div_d = div_q;
    if (open_burst) div_d = cfg_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  half_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  frame_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .three_wire(cfg_three_wire), .is_data(in_is_data), .byte_in(in_byte),
    .sdo(sdo), .last(last)
  );

  link_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_data(in_is_data),
    .three_wire(cfg_three_wire), .tick(tick), .last(last), .load(load),
    .shift(shift), .in_ready(in_ready), .busy(busy), .sclk(sclk),
    .cs_n(cs_n), .dc(dc)
  );

  // R2: clock stays low outside the select window
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R5: data is frozen through the high phase
  assert_sdo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));
endmodule

// File: tb/sim_panel_serial_tx.sv
module sim_panel_serial_tx;
  logic       clk = 1'b0;
  logic       rst_n, cfg_three_wire, in_valid, in_is_data;
  logic [7:0] cfg_div, in_byte;
  logic       in_ready, sclk, sdo, cs_n, dc;

  always #4 clk = ~clk;

  panel_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_three_wire(cfg_three_wire), .cfg_div(cfg_div),
    .in_valid(in_valid), .in_is_data(in_is_data), .in_byte(in_byte),
    .in_ready(in_ready), .sclk(sclk), .sdo(sdo), .cs_n(cs_n), .dc(dc)
  );

  int total = 0, bad = 0;
  bit done = 0, mon_en = 0;
  int cur_div = 0;
  bit cur_mode = 0;
  logic [7:0] exp_byte [0:511];
  bit         exp_tag  [0:511];
  int rx_idx = 0, cs_rises = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitor, sampled on the falling clock edge
  bit p_sclk = 0, p_cs = 1, p_sdo = 0, f_dc = 0, hi_sdo = 0;
  int run = 0, bits = 0;
  logic [8:0] acc = '0;

  always @(negedge clk) begin
    if (mon_en) begin
      bit ev;
      ev = (sclk != p_sclk) || (cs_n != p_cs);
      if (sclk && !p_sclk) begin
        if (!cs_n) chk(run == cur_div + 1, "R2 half period before rise", run, cur_div + 1);
        acc = {acc[7:0], sdo};
        if (bits == 0) f_dc = dc;
        else chk(dc == f_dc, "R3 dc constant within frame", dc, f_dc);
        hi_sdo = sdo;
        bits++;
        if (bits == (cur_mode ? 9 : 8)) begin
          if (cur_mode) begin
            chk(acc == {exp_tag[rx_idx], exp_byte[rx_idx]}, "R4 tagged 9-bit frame",
                acc, {exp_tag[rx_idx], exp_byte[rx_idx]});
            chk(f_dc == 0, "R4 dc held low", f_dc, 0);
          end else begin
            chk(acc[7:0] == exp_byte[rx_idx], "R3 byte msb first", acc[7:0], exp_byte[rx_idx]);
            chk(f_dc == exp_tag[rx_idx], "R3 dc tag", f_dc, exp_tag[rx_idx]);
          end
          rx_idx++;
          bits = 0;
        end
      end
      if (!sclk && p_sclk) begin
        chk(run == cur_div + 1, "R2 high phase length", run, cur_div + 1);
        chk(p_sdo == hi_sdo, "R5 sdo stable while high", p_sdo, hi_sdo);
      end
      if (cs_n && !p_cs) begin
        cs_rises++;
        chk(run == cur_div + 1, "R7 tail after last fall", run, cur_div + 1);
        chk(bits == 0, "R7 no mid-frame close", bits, 0);
        chk(sclk == 0, "R2 sclk low when deselected", sclk, 0);
      end
      if (ev) run = 1; else run++;
      p_sclk = sclk; p_cs = cs_n; p_sdo = sdo;
    end
  end

  task automatic run_burst(input int n, input bit mode, input int div,
                           input int seed, input int mult, input bit gaps);
    cur_mode = mode; cur_div = div;
    rx_idx = 0; cs_rises = 0;
    for (int i = 0; i < n; i++) begin
      exp_byte[i] = 8'((i * mult + seed) & 255);
      exp_tag[i]  = ((i + seed) % 3) != 0;
    end
    @(negedge clk);
    cfg_three_wire = mode;
    cfg_div = 8'(div);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_byte = exp_byte[i];
      in_is_data = exp_tag[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (gaps) begin
        in_valid = 1'b0;
        while (!cs_n) @(negedge clk);
        repeat (2) @(negedge clk);
      end
    end
    in_valid = 1'b0;
    while (!cs_n) @(negedge clk);
    repeat (div + 4) @(negedge clk);
    chk(rx_idx == n, mode ? "R4 frame count" : "R3 frame count", rx_idx, n);
    chk(cs_rises == (gaps ? n : 1), "R6 select windows per burst", cs_rises, gaps ? n : 1);
    chk(in_ready == 1, "R7 ready in idle", in_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_is_data = 1'b0; in_byte = '0;
    cfg_three_wire = 1'b0; cfg_div = '0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1, "R1 cs_n in reset", cs_n, 1);
    chk(sclk == 0, "R1 sclk in reset", sclk, 0);
    chk(sdo == 0 && dc == 0, "R1 sdo/dc in reset", {sdo, dc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0, "R1 idle after reset", {cs_n, sclk}, 2);
    chk(in_ready == 1, "R1 ready after reset", in_ready, 1);
    mon_en = 1;
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < 4; d++) begin
        run_burst(6, bit'(m), d, d * 5 + m, 37, 1'b0);
        run_burst(3, bit'(m), d, d * 7 + 1, 53, 1'b1);
      end
      run_burst(256, bit'(m), 0, 0, 1, 1'b0);
      run_burst(2, bit'(m), 255, 11, 97, 1'b0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule